// File: doc/BRIEF.md
# Synthesizer Divider Configuration Register

This block holds the divider settings of a PLL clock synthesizer: a 7-bit feedback divide value, a 2-bit output-divide code and a 3-bit test-mode select. Two load paths feed the same output registers. A parallel path takes the feedback and output-divide values from static pins. A serial path assembles a 12-bit word in a shift register and commits it on a strobe.

All four control inputs (serial clock, serial data, serial load strobe, parallel load) and the parallel pins are brought into the system clock domain through a synchronizer chain. Edges are found there; none of these inputs is used as a clock. A two-state controller decides which path owns the registers. In state TRACK, the registers follow the parallel pins and the test select is held at 000. The controller takes transition TRACK→ARMED when the synchronized parallel load goes high; that rising edge is the parallel capture. In state ARMED, the registers hold their value and only a falling edge of the serial load strobe rewrites them. The controller takes transition ARMED→TRACK when the synchronized parallel load goes low. That transition outranks a serial commit in the same cycle.

Top module: `synth_cfg_if`

## Requirements
- R1: The serial shift register advances by one bit on each rising edge of `ser_clk`, moving `ser_din` into bit 0, so the first bit sent ends up in bit 11. When more than 12 bits are sent, only the last 12 remain. The word layout is test select in bits 11:9, output divide in bits 8:7 and feedback value in bits 6:0.
- R2: While `par_load` is high, a falling edge of `ser_load` copies the shift-register word into `cfg_t`, `cfg_n` and `cfg_m`. A rising edge of `ser_load` changes nothing.
- R3: Shifting bits with no `ser_load` falling edge leaves all three outputs unchanged.
- R4: While `par_load` is low, `ser_load` falling edges are ignored, and `cfg_m`/`cfg_n` follow `par_m`/`par_n` within 5 clock cycles.
- R5: A rising edge of `par_load` captures `par_m` and `par_n`. While `par_load` stays high, later changes on those pins do not reach the outputs.
- R6: `cfg_t` reads 000 whenever the parallel path owns the registers: after reset, while `par_load` is low, and after a parallel capture.
- R7: If `par_load` falls in the same cycle as a `ser_load` falling edge, the parallel path wins. The outputs take the pin values and `cfg_t` is 000.
- R8: While `rst_n` is low, all outputs are zero. After release with `par_load` low, `cfg_m` and `cfg_n` equal the parallel pins within 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (sampled, rising edge shifts) |
| ser_din | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial commit strobe (falling edge commits) |
| par_load | input | 1 | Parallel load (rising edge captures, low tracks pins) |
| par_m | input | 7 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output-divide code |
| cfg_m | output | 7 | Registered feedback divide value |
| cfg_n | output | 2 | Registered output-divide code |
| cfg_t | output | 3 | Registered test-mode select |

## Verification
The assertions check, on every cycle, the following properties:
- the shift register takes exactly one step per detected serial clock edge;
- edge pulses last a single cycle;
- the test select stays zero in TRACK;
- the registers hold steady in ARMED unless a serial commit arrives;
- a commit copies the shift word;
- a low parallel load in ARMED returns the controller to TRACK with the test select cleared.

Only the bench scenarios can show end-to-end behaviour through the synchronizers. That includes the bit order of a complete word as sent on the pins, a 15-bit overshift keeping only the last 12 bits, and pin changes being ignored after a capture. It also covers the simultaneous parallel-fall and serial-fall case, and the values seen during and just after reset.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int M_W    = 7;
    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int WORD_W = T_W + N_W + M_W;

    // Serial word layout: test select on top, then output divide, then feedback
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    typedef enum logic {
        S_TRACK = 1'b0,
        S_ARMED = 1'b1
    } mode_e;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scfg_edge.sv
module scfg_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    if (RISING) begin : g_rise
        assign pulse = lvl & ~prev_q;
    end else begin : g_fall
        assign pulse = ~lvl & prev_q;
    end

    // R1/R2: a detected edge is a single-cycle event
    p_pulse_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word <= '0;
        else if (step) word <= {word[W-2:0], din};
    end

    p_shift_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (word[W-1:1] == $past(word[W-2:0])) && (word[0] == $past(din)));

    p_shift_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(word));
endmodule

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_lvl,
    input  logic              ser_fall,
    input  logic [M_W-1:0]    pin_m,
    input  logic [N_W-1:0]    pin_n,
    input  logic [WORD_W-1:0] shift_word,
    output cfg_word_t         cfg_q
);
    mode_e     state_q, state_d;
    cfg_word_t pin_word;
    cfg_word_t ser_word;

    always_comb begin
        pin_word.t = '0;
        pin_word.n = pin_n;
        pin_word.m = pin_m;
    end

    assign ser_word = cfg_word_t'(shift_word);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_TRACK: if (par_lvl)  state_d = S_ARMED;
            S_ARMED: if (!par_lvl) state_d = S_TRACK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_TRACK;
        else        state_q <= state_d;
    end

    // configuration registers; the parallel path outranks serial commits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            unique case (state_q)
                S_TRACK: cfg_q <= pin_word;
                S_ARMED: begin
                    if (!par_lvl)     cfg_q <= pin_word;
                    else if (ser_fall) cfg_q <= ser_word;
                end
            endcase
        end
    end

    p_track_t_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRACK) |-> (cfg_q.t == '0));

    p_track_follows_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRACK) |=> (cfg_q.m == $past(pin_m)) && (cfg_q.n == $past(pin_n)));

    p_hold_without_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && par_lvl && !ser_fall) |=> $stable(cfg_q));

    p_serial_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && par_lvl && ser_fall) |=> (cfg_q == $past(ser_word)));

    p_par_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && !par_lvl) |=> (state_q == S_TRACK) && (cfg_q.t == '0));
endmodule

// File: rtl/synth_cfg_if.sv
module synth_cfg_if
    import scfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_din,
    input  logic           ser_load,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t
);
    localparam int CTL_W = 4;
    localparam int PIN_W = M_W + N_W;

    logic [CTL_W-1:0] ctl_s;
    logic [PIN_W-1:0] pins_s;
    logic             ser_clk_s, ser_din_s, ser_load_s, par_load_s;
    logic             ser_rise, ser_fall;
    logic [WORD_W-1:0] shift_word;
    cfg_word_t         cfg_q;

    scfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({ser_clk, ser_din, ser_load, par_load}),
        .q(ctl_s)
    );

    scfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync_pins (
        .clk(clk), .rst_n(rst_n),
        .d({par_n, par_m}),
        .q(pins_s)
    );

    assign {ser_clk_s, ser_din_s, ser_load_s, par_load_s} = ctl_s;

    scfg_edge #(.RISING(1'b1)) u_edge_sclk (
        .clk(clk), .rst_n(rst_n), .lvl(ser_clk_s), .pulse(ser_rise)
    );

    scfg_edge #(.RISING(1'b0)) u_edge_sload (
        .clk(clk), .rst_n(rst_n), .lvl(ser_load_s), .pulse(ser_fall)
    );

    scfg_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .step(ser_rise), .din(ser_din_s), .word(shift_word)
    );

    scfg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .par_lvl(par_load_s), .ser_fall(ser_fall),
        .pin_m(pins_s[M_W-1:0]), .pin_n(pins_s[PIN_W-1:M_W]),
        .shift_word(shift_word),
        .cfg_q(cfg_q)
    );

    assign cfg_m = cfg_q.m;
    assign cfg_n = cfg_q.n;
    assign cfg_t = cfg_q.t;
endmodule

// File: tb/synth_cfg_if_test.sv
module synth_cfg_if_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0, par_load = 1'b0;
    logic [6:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [6:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    synth_cfg_if uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] et, input logic [1:0] en, input logic [6:0] em);
        n_chk++;
        if ({cfg_t, cfg_n, cfg_m} !== {et, en, em}) begin
            n_fail++;
            $display("FAIL %s actual t=%b n=%b m=%h expected t=%b n=%b m=%h",
                     req, cfg_t, cfg_n, cfg_m, et, en, em);
        end
    endtask

    // first bit sent lands in bit 11
    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i];
            cyc(3);
            ser_clk = 1'b1;
            cyc(3);
            ser_clk = 1'b0;
        end
        cyc(3);
    endtask

    task automatic strobe();
        ser_load = 1'b1;
        cyc(5);
        ser_load = 1'b0;
        cyc(5);
    endtask

    task automatic t_reset();
        par_m = 7'h55; par_n = 2'd2;
        cyc(3);
        chk("R8 zero during reset", 3'b0, 2'b0, 7'h0);
        rst_n = 1'b1;
        cyc(5);
        chk("R8 pins after release", 3'b0, 2'd2, 7'h55);
        chk("R6 t zero after reset", 3'b0, cfg_n, cfg_m);
    endtask

    task automatic t_track();
        par_m = 7'h1C; par_n = 2'd3;
        cyc(5);
        chk("R4 follow pins", 3'b0, 2'd3, 7'h1C);
        shift_bits({4'h0, 3'b110, 2'b01, 7'h7E}, 12);
        strobe();
        chk("R4 serial commit ignored in track", 3'b0, 2'd3, 7'h1C);
    endtask

    task automatic t_capture();
        par_m = 7'h23; par_n = 2'd1;
        par_load = 1'b1;
        cyc(5);
        chk("R5 capture on rise", 3'b0, 2'd1, 7'h23);
        par_m = 7'h11; par_n = 2'd0;
        cyc(6);
        chk("R5 pin change ignored", 3'b0, 2'd1, 7'h23);
        chk("R6 t zero after capture", 3'b0, cfg_n, cfg_m);
    endtask

    task automatic t_serial_commit();
        shift_bits({4'h0, 3'b101, 2'b10, 7'h6A}, 12);
        chk("R3 shift alone no change", 3'b0, 2'd1, 7'h23);
        ser_load = 1'b1;
        cyc(6);
        chk("R2 rising strobe no change", 3'b0, 2'd1, 7'h23);
        ser_load = 1'b0;
        cyc(5);
        chk("R2 commit on falling strobe", 3'b101, 2'b10, 7'h6A);
        chk("R1 bit order of word", 3'b101, 2'b10, 7'h6A);
    endtask

    task automatic t_overshift();
        shift_bits({1'b0, 3'b111, 3'b011, 2'b01, 7'h15}, 15);
        chk("R3 overshift no change before strobe", 3'b101, 2'b10, 7'h6A);
        strobe();
        chk("R1 only last 12 bits kept", 3'b011, 2'b01, 7'h15);
    endtask

    task automatic t_priority();
        shift_bits({4'h0, 3'b111, 2'b11, 7'h7F}, 12);
        ser_load = 1'b1;
        cyc(5);
        par_m = 7'h40; par_n = 2'd2;
        ser_load = 1'b0;
        par_load = 1'b0;
        cyc(6);
        chk("R7 parallel wins same cycle", 3'b0, 2'd2, 7'h40);
        par_m = 7'h09; par_n = 2'd0;
        cyc(5);
        chk("R4 tracking after release", 3'b0, 2'd0, 7'h09);
        strobe();
        chk("R4 strobe ignored while low", 3'b0, 2'd0, 7'h09);
    endtask

    task automatic t_recapture();
        par_load = 1'b1;
        cyc(5);
        chk("R6 t zero on recapture", 3'b0, 2'd0, 7'h09);
        shift_bits({4'h0, 3'b001, 2'b11, 7'h02}, 12);
        strobe();
        chk("R2 second commit", 3'b001, 2'b11, 7'h02);
    endtask

    initial begin
        t_reset();
        t_track();
        t_capture();
        t_serial_commit();
        t_overshift();
        t_priority();
        t_recapture();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule